// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block keeps an asynchronous DRAM alive. After reset it counts out a start-up delay. It then borrows the strobe bus from the access sequencer and issues a fixed burst of warm-up refresh cycles back to back. Once that burst is finished it raises `ready`. From then on an interval divider produces one refresh obligation per slot, so that every row is covered within the refresh period.

Each refresh cycle pulls the column strobes low before the row strobes, as the memory's internal row counter requires. Write enable stays high throughout, so no test mode is entered. All four row strobes move together, and so do all four column strobes, which means both ranks refresh at once. If the access sequencer keeps a page open and withholds the bus, the owed refreshes collect in a small pending counter. When that counter fills, `urgent` is raised so the sequencer closes its page and hands over the bus.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ready`, `bus_req`, `strobe_en` and `urgent` are 0, all eight strobes are high (1) and `we_n` is 1.
- R2: `bus_req` first rises exactly STARTUP_CYC clock cycles after reset is released.
- R3: INIT_REFRESHES refresh cycles run under a single grant with exactly PRE_CYC precharge cycles between them. `ready` rises after the last of them, before any further refresh, and never falls again.
- R4: In every refresh cycle the column strobes go low exactly CSR_CYC cycles before the row strobes. The row strobes then stay low for exactly ACT_CYC cycles, and row and column strobes return high on the same edge.
- R5: Between the end of one refresh and the next column strobe fall, all strobes stay high for at least PRE_CYC cycles.
- R6: `we_n` is 1 in every cycle in which any strobe is low.
- R7: The four row strobes always carry the same value, and the four column strobes always carry the same value.
- R8: No strobe goes low unless `bus_grant` was seen while `bus_req` was high. `bus_req` and `strobe_en` stay high for as long as any strobe is low.
- R9: Once `ready` is high and the bus is granted at once, row strobe falls of successive refreshes are exactly INTERVAL_CYC cycles apart.
- R10: Each interval slot that passes without a completed refresh adds one to a pending count that saturates at MAX_PENDING, and further slots are dropped. `urgent` is high while the count is full. After a grant, exactly the pending number of refreshes is served and `urgent` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_grant | input | 1 | Access sequencer hands over the strobe bus |
| bus_req | output | 1 | Request for the strobe bus, held through the refresh |
| strobe_en | output | 1 | High while this block drives the strobes |
| ras_n | output | 4 | Row strobes, active low, one per rank half |
| cas_n | output | 4 | Column strobes, active low, one per byte lane |
| we_n | output | 1 | Write enable, kept high |
| urgent | output | 1 | Pending refresh count is full |
| ready | output | 1 | Warm-up refresh burst complete |

## Verification
The bench builds the scheduler with a 30-cycle start-up delay, a 50-cycle interval, a pending limit of 4, and strobe phases of 2, 4 and 3 cycles. The warm-up count stays at 8. These shortened values let a single run cover the start-up wait, the full warm-up burst, several evenly spaced refreshes, and a withheld grant long enough to fill the pending counter and then drop two further slots. Once the grant returns, the run confirms that exactly four refreshes are served.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int STARTUP_CYC    = 40000,
  parameter int INIT_REFRESHES = 8,
  parameter int INTERVAL_CYC   = 3120,
  parameter int MAX_PENDING    = 8,
  parameter int CSR_CYC        = 2,
  parameter int ACT_CYC        = 12,
  parameter int PRE_CYC        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_grant,
  output logic       bus_req,
  output logic       strobe_en,
  output logic [3:0] ras_n,
  output logic [3:0] cas_n,
  output logic       we_n,
  output logic       urgent,
  output logic       ready
);
  localparam int TW = $clog2(STARTUP_CYC + CSR_CYC + ACT_CYC + PRE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam int PW = $clog2(MAX_PENDING + 1);
  localparam int NW = $clog2(INIT_REFRESHES + 1);

  typedef enum logic [2:0] {S_WAIT, S_REQ, S_SETUP, S_ACT, S_PRE, S_IDLE} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] ivl;
  logic [PW-1:0] pend;
  logic [NW-1:0] init_left;

  wire tick   = ready && (ivl == IW'(INTERVAL_CYC - 1));
  wire done   = (st == S_PRE) && (tmr == TW'(PRE_CYC - 1));
  wire served = done && ready;
  wire busy   = (st == S_SETUP) || (st == S_ACT) || (st == S_PRE);

  assign bus_req   = (st == S_REQ) || busy;
  assign strobe_en = busy;
  assign cas_n     = {4{~((st == S_SETUP) || (st == S_ACT))}};
  assign ras_n     = {4{~(st == S_ACT)}};
  assign we_n      = 1'b1;
  assign urgent    = (pend == PW'(MAX_PENDING));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ivl <= '0;
    else if (ready) ivl <= tick ? '0 : ivl + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else if (tick && !served && !urgent) pend <= pend + 1'b1;
    else if (served && !tick) pend <= pend - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      tmr       <= '0;
      ready     <= 1'b0;
      init_left <= NW'(INIT_REFRESHES);
    end else begin
      case (st)
        S_WAIT:
          if (tmr == TW'(STARTUP_CYC - 1)) begin st <= S_REQ; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_REQ:
          if (bus_grant) begin st <= S_SETUP; tmr <= '0; end
        S_SETUP:
          if (tmr == TW'(CSR_CYC - 1)) begin st <= S_ACT; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_ACT:
          if (tmr == TW'(ACT_CYC - 1)) begin st <= S_PRE; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_PRE:
          if (done) begin
            tmr <= '0;
            if (ready) st <= S_IDLE;
            else if (init_left == NW'(1)) begin ready <= 1'b1; st <= S_IDLE; end
            else begin init_left <= init_left - 1'b1; st <= S_SETUP; end
          end else tmr <= tmr + 1'b1;
        S_IDLE:
          if (pend != '0) st <= S_REQ;
        default: st <= S_WAIT;
      endcase
    end
  end

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[0] |-> !cas_n[0]);

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> $past(!cas_n[0]));

  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R8
  strobe_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n[0] |-> (bus_req && strobe_en));

  // R7
  lanes_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == 4'h0 || ras_n == 4'hF) && (cas_n == 4'h0 || cas_n == 4'hF));

  // R10
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PENDING));
endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
  localparam int STARTUP = 30, INIT = 8, INTERVAL = 50, MAXP = 4;
  localparam int CSR = 2, ACT = 4, PRE = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_grant, bus_req, strobe_en, we_n, urgent, ready;
  logic [3:0] ras_n, cas_n;

  dram_refresh_sched #(.STARTUP_CYC(STARTUP), .INIT_REFRESHES(INIT), .INTERVAL_CYC(INTERVAL),
    .MAX_PENDING(MAXP), .CSR_CYC(CSR), .ACT_CYC(ACT), .PRE_CYC(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req), .strobe_en(strobe_en),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .urgent(urgent), .ready(ready));

  int errs = 0, checks = 0, cyc = 0;
  bit finished = 0;
  int exp_q[$];
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  logic [3:0] pr = 4'hF, pc = 4'hF;
  int cas_fall = -1, ras_fall = -1, last_rise = -1, run_fall = -1, rcount = 0;
  bit spacing_on = 0;

  always @(negedge clk) if (rst_n) begin
    if (ras_n != pr || cas_n != pc) begin
      chk((ras_n == 4'h0 || ras_n == 4'hF) && (cas_n == 4'h0 || cas_n == 4'hF), "R7", "lanes", ras_n, 0);
    end
    if (cas_n != 4'hF) begin
      chk(we_n == 1'b1, "R6", "we_n", we_n, 1);
      chk(strobe_en && bus_req, "R8", "ownership", strobe_en, 1);
    end
    if (pc == 4'hF && cas_n == 4'h0) begin
      cas_fall = cyc;
      if (last_rise >= 0) begin
        chk(cyc - last_rise >= PRE, "R5", "precharge", cyc - last_rise, PRE);
        if (!ready) chk(cyc - last_rise == PRE, "R3", "init gap", cyc - last_rise, PRE);
      end
    end
    if (pr == 4'hF && ras_n == 4'h0) begin
      ras_fall = cyc;
      chk(cyc - cas_fall == CSR, "R4", "cas lead", cyc - cas_fall, CSR);
      if (exp_q.size() == 0) chk(0, "R8", "unexpected refresh", 1, 0);
      else begin
        int tag;
        tag = exp_q.pop_front();
        chk(tag == int'(ready), "R3", "phase tag", int'(ready), tag);
      end
      if (spacing_on && ready) begin
        if (run_fall >= 0) chk(cyc - run_fall == INTERVAL, "R9", "spacing", cyc - run_fall, INTERVAL);
        run_fall = cyc;
      end
    end
    if (pr == 4'h0 && ras_n == 4'hF) begin
      chk(cas_n == 4'hF, "R4", "joint rise", cas_n, 4'hF);
      chk(cyc - ras_fall == ACT, "R4", "active width", cyc - ras_fall, ACT);
      last_rise = cyc;
      rcount++;
    end
    pr = ras_n;
    pc = cas_n;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "all", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int rel, rc0;
    rst_n = 1'b0;
    bus_grant = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ready && !bus_req && !strobe_en && !urgent, "R1", "reset outputs", {ready, bus_req, strobe_en, urgent}, 0);
    chk(ras_n == 4'hF && cas_n == 4'hF && we_n, "R1", "reset strobes", {ras_n, cas_n, we_n}, 9'h1FF);
    for (int i = 0; i < INIT; i++) exp_q.push_back(0);
    rst_n = 1'b1;
    rel = cyc;
    while (!bus_req) @(negedge clk);
    chk(cyc - rel == STARTUP, "R2", "startup wait", cyc - rel, STARTUP);
    while (!ready) @(negedge clk);
    chk(rcount == INIT, "R3", "warm-up count", rcount, INIT);
    chk(exp_q.size() == 0, "R3", "warm-up items left", exp_q.size(), 0);

    spacing_on = 1;
    for (int i = 0; i < 3; i++) exp_q.push_back(1);
    while (exp_q.size() != 0) @(negedge clk);
    while (bus_req) @(negedge clk);
    spacing_on = 0;
    chk(run_fall >= 0, "R9", "run refresh seen", run_fall >= 0, 1);

    bus_grant = 1'b0;
    rc0 = rcount;
    while (!urgent) @(negedge clk);
    chk(rcount == rc0, "R8", "no refresh without grant", rcount - rc0, 0);
    chk(bus_req == 1'b1, "R10", "request held", bus_req, 1);
    repeat (2 * INTERVAL) @(negedge clk);
    chk(urgent == 1'b1, "R10", "urgent kept", urgent, 1);
    chk(rcount == rc0, "R8", "still no refresh", rcount - rc0, 0);
    for (int i = 0; i < MAXP; i++) exp_q.push_back(1);
    bus_grant = 1'b1;
    while (exp_q.size() != 0 || bus_req) @(negedge clk);
    chk(urgent == 1'b0, "R10", "urgent cleared", urgent, 0);
    chk(rcount - rc0 == MAXP, "R10", "served count", rcount - rc0, MAXP);
    bus_grant = 1'b0;
    repeat (INTERVAL + 5) @(negedge clk);
    chk(rcount - rc0 == MAXP, "R10", "dropped slots", rcount - rc0, MAXP);
    chk(ready == 1'b1, "R3", "ready stays", ready, 1);
    finish_run();
  end
endmodule